// File: doc/BRIEF.md
# Processor Low-Power State Sequencer

This block steps a processor core through its power states: running, halted after an idle instruction, stop-granted, a short sub-state used to serve bus snoops and interrupts, and sleep with the clocks gated. A stop-clock request from the platform makes the sequencer ask the bus engine to issue a stop-grant acknowledge. The sequencer then waits for the response phase of that cycle and counts a fixed delay before it reports Stop-Grant. From Stop-Grant, a sleep request gates all internal clocks. The sequencer also asks the PLL to hold lock during sleep.

Side-band events (SMI, INIT and two local interrupt lines) and bus-delivered interrupts that arrive while the core is stopped are held in one-shot latches. The pending-break-event output tells the platform that something is waiting. On the first running cycle after the stop, every latched event is handed to the core for exactly one cycle. The sequencer also checks the platform's side of the protocol and keeps three sticky error flags: a sleep request in the wrong state, a stop-clock request released too soon after sleep, and bus input activity during sleep.

Top module: `lp_state_seq`

## Requirements
- R1: When `stop_req_n` is low in Normal (state code 0), the next state is acknowledge-wait (code 2) and `ack_req` is high. The edge that samples `ack_resp` high moves to the entry count (code 3). Stop-Grant (code 4) is entered on exactly the ENTRY_DLY-th edge after that edge.
- R2: In Stop-Grant, with `sleep_req_n`, `snoop_act` and `bus_intr` inactive, `stop_req_n` high returns the state to Normal at the next edge.
- R3: Low `core_rst_n` in Stop-Grant leaves the state at Stop-Grant. Low `core_rst_n` in Normal or AutoHALT forces Normal and clears all pending latches, so `svc_o` reads 0.
- R4: Sleep (code 6) is entered only from Stop-Grant on low `sleep_req_n`. Low `sleep_req_n` in any state other than Stop-Grant or Sleep causes no transition and sets the sticky flag `slp_err`.
- R5: In Sleep, `clk_en` is 0 and `pll_keep` is 1; in every other state, `clk_en` is 1 and `pll_keep` is 0. `snoop_act` does not move the state out of Sleep.
- R6: High `sleep_req_n` in Sleep returns the state to Stop-Grant; call that edge 0. If `stop_req_n` is first sampled high at edge k with 1 <= k < MIN_HOLD, the sticky flag `hold_err` is set. For k >= MIN_HOLD, `hold_err` stays clear.
- R7: `snoop_act` or `bus_intr` high in Stop-Grant or AutoHALT (code 1) moves the state to the snoop sub-state (code 5). The state stays there while `snoop_act` is high, then returns to the state it came from.
- R8: `evt_in` bit 0 is SMI, bit 1 INIT, bit 2 LINT0 and bit 3 LINT1. These bits are latched in Stop-Grant and in the snoop sub-state. `bus_intr` is latched as bit 4 in AutoHALT, Stop-Grant and the snoop sub-state. In the first Normal cycle, `svc_o` shows each latched source once, however many pulses arrived, and then reads 0 from the next cycle.
- R9: `pbe` is high exactly when the state is Stop-Grant and at least one latch is pending; there is no interrupt-masking input.
- R10: Any change of `stop_req_n`, `halt_req`, `snoop_act`, `bus_intr`, `ack_resp` or `evt_in` between consecutive Sleep cycles sets the sticky flag `bus_err`.
- R11: `halt_req` high in Normal enters AutoHALT, and `halt_req` low in AutoHALT returns to Normal. In Normal, `stop_req_n` low takes priority over `halt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req_n | input | 1 | Stop-clock request, active low |
| sleep_req_n | input | 1 | Sleep request, active low |
| core_rst_n | input | 1 | Functional core reset, active low |
| halt_req | input | 1 | Core has executed an idle halt |
| snoop_act | input | 1 | Snoop transaction in progress on the bus |
| bus_intr | input | 1 | Interrupt delivered over the bus, strobe |
| ack_resp | input | 1 | Response phase of the stop-grant acknowledge cycle |
| evt_in | input | 4 | Side-band events: SMI, INIT, LINT0, LINT1 |
| state_o | output | 3 | Current state code |
| ack_req | output | 1 | Request to issue the stop-grant acknowledge cycle |
| clk_en | output | 1 | Internal clock enable |
| pll_keep | output | 1 | Hold PLL lock while clocks are gated |
| pbe | output | 1 | Pending break event |
| svc_o | output | 5 | Latched events released to the core |
| slp_err | output | 1 | Sticky: sleep request in an illegal state |
| hold_err | output | 1 | Sticky: stop-clock released too early after sleep |
| bus_err | output | 1 | Sticky: bus input changed during sleep |

## Verification
The bench builds the sequencer with ENTRY_DLY = 5 and MIN_HOLD = 4. With these short counts, it checks every cycle of the entry wait. It also sweeps every stop-clock release offset from 1 to MIN_HOLD + 2 after leaving sleep, and it expects `hold_err` exactly below MIN_HOLD. All 16 side-band masks are applied twice each while stopped, which exercises the one-shot release and `pbe` for every combination of sources.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [2:0] {
    PS_NORM = 3'd0,
    PS_HALT = 3'd1,
    PS_ACKW = 3'd2,
    PS_ENTR = 3'd3,
    PS_STPG = 3'd4,
    PS_SNP  = 3'd5,
    PS_SLP  = 3'd6
  } pstate_t;

  localparam int NSB   = 4;        // side-band sources
  localparam int NPEND = NSB + 1;  // plus bus interrupt
  localparam int NWAT  = NSB + 5;  // inputs watched during sleep
endpackage

// File: rtl/lp_fsm.sv
module lp_fsm
  import lp_pkg::*;
#(
  parameter int ENTRY_DLY = 20,
  parameter int MIN_HOLD  = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stop_req_n,
  input  logic    sleep_req_n,
  input  logic    core_rst_n,
  input  logic    halt_req,
  input  logic    snoop_act,
  input  logic    bus_intr,
  input  logic    ack_resp,
  output pstate_t st,
  output logic    hold_act
);
  localparam int CW = $clog2(ENTRY_DLY + 1);
  localparam int HW = $clog2(MIN_HOLD + 1);

  pstate_t       st_nx;
  logic [CW-1:0] ent_cnt, ent_cnt_nx;
  logic [HW-1:0] hold_cnt, hold_cnt_nx;
  logic          ret_ah, ret_ah_nx;
  logic          ret_en;

  always_comb begin
    st_nx      = st;
    ent_cnt_nx = ent_cnt;
    ret_en     = 1'b0;
    ret_ah_nx  = ret_ah;
    case (st)
      PS_NORM: begin
        if (!core_rst_n)     st_nx = PS_NORM;
        else if (!stop_req_n) st_nx = PS_ACKW;
        else if (halt_req)   st_nx = PS_HALT;
      end
      PS_HALT: begin
        if (!core_rst_n) st_nx = PS_NORM;
        else if (snoop_act || bus_intr) begin
          st_nx     = PS_SNP;
          ret_en    = 1'b1;
          ret_ah_nx = 1'b1;
        end else if (!halt_req) st_nx = PS_NORM;
      end
      PS_ACKW: begin
        if (ack_resp) begin
          st_nx      = PS_ENTR;
          ent_cnt_nx = CW'(ENTRY_DLY - 1);
        end
      end
      PS_ENTR: begin
        if (ent_cnt == '0) st_nx = PS_STPG;
        else               ent_cnt_nx = ent_cnt - 1'b1;
      end
      PS_STPG: begin
        if (!sleep_req_n) st_nx = PS_SLP;
        else if (snoop_act || bus_intr) begin
          st_nx     = PS_SNP;
          ret_en    = 1'b1;
          ret_ah_nx = 1'b0;
        end else if (stop_req_n) st_nx = PS_NORM;
      end
      PS_SNP: begin
        if (!snoop_act) st_nx = ret_ah ? PS_HALT : PS_STPG;
      end
      PS_SLP: begin
        if (sleep_req_n) st_nx = PS_STPG;
      end
      default: st_nx = PS_NORM;
    endcase
  end

  always_comb begin
    if (st == PS_SLP && sleep_req_n) hold_cnt_nx = HW'(MIN_HOLD - 1);
    else if (hold_cnt != '0)         hold_cnt_nx = hold_cnt - 1'b1;
    else                             hold_cnt_nx = hold_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_NORM;
      ent_cnt  <= '0;
      hold_cnt <= '0;
      ret_ah   <= 1'b0;
    end else begin
      st       <= st_nx;
      ent_cnt  <= ent_cnt_nx;
      hold_cnt <= hold_cnt_nx;
      if (ret_en) ret_ah <= ret_ah_nx;
    end
  end

  assign hold_act = (hold_cnt != '0);
endmodule

// File: rtl/lp_evt_latch.sv
module lp_evt_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q, q_nx;
    always_comb begin
      if (clr_i)         q_nx = 1'b0;
      else if (set_i[g]) q_nx = 1'b1;
      else               q_nx = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_nx;
    end
    assign pend_o[g] = q;
  end
endmodule

// File: rtl/lp_err_mon.sv
module lp_err_mon
  import lp_pkg::*;
#(
  parameter int WW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pstate_t       st,
  input  logic          sleep_req_n,
  input  logic          stop_req_n,
  input  logic          hold_act,
  input  logic [WW-1:0] watch,
  output logic          slp_err,
  output logic          hold_err,
  output logic          bus_err
);
  logic [WW-1:0] watch_q;
  logic          slp_set, hold_set, bus_set;

  always_comb begin
    slp_set  = !sleep_req_n && (st != PS_STPG) && (st != PS_SLP);
    hold_set = (st == PS_STPG) && hold_act && stop_req_n;
    bus_set  = (st == PS_SLP) && (watch != watch_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      watch_q  <= '0;
      slp_err  <= 1'b0;
      hold_err <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      watch_q <= watch;
      if (slp_set)  slp_err  <= 1'b1;
      if (hold_set) hold_err <= 1'b1;
      if (bus_set)  bus_err  <= 1'b1;
    end
  end
endmodule

// File: rtl/lp_state_seq.sv
module lp_state_seq
  import lp_pkg::*;
#(
  parameter int ENTRY_DLY = 20,
  parameter int MIN_HOLD  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic             sleep_req_n,
  input  logic             core_rst_n,
  input  logic             halt_req,
  input  logic             snoop_act,
  input  logic             bus_intr,
  input  logic             ack_resp,
  input  logic [NSB-1:0]   evt_in,
  output logic [2:0]       state_o,
  output logic             ack_req,
  output logic             clk_en,
  output logic             pll_keep,
  output logic             pbe,
  output logic [NPEND-1:0] svc_o,
  output logic             slp_err,
  output logic             hold_err,
  output logic             bus_err
);
  pstate_t          st;
  logic             hold_act;
  logic [NPEND-1:0] pend, set_v;
  logic             sb_en, bi_en, clr;

  lp_fsm #(.ENTRY_DLY(ENTRY_DLY), .MIN_HOLD(MIN_HOLD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n),
    .sleep_req_n(sleep_req_n), .core_rst_n(core_rst_n),
    .halt_req(halt_req), .snoop_act(snoop_act), .bus_intr(bus_intr),
    .ack_resp(ack_resp), .st(st), .hold_act(hold_act)
  );

  always_comb begin
    sb_en = (st == PS_STPG) || (st == PS_SNP);
    bi_en = sb_en || (st == PS_HALT);
    clr   = (st == PS_NORM) || ((st == PS_HALT) && !core_rst_n);
    set_v = {bus_intr & bi_en, evt_in & {NSB{sb_en}}};
  end

  lp_evt_latch #(.W(NPEND)) u_lat (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .clr_i(clr), .pend_o(pend)
  );

  lp_err_mon #(.WW(NWAT)) u_err (
    .clk(clk), .rst_n(rst_n), .st(st), .sleep_req_n(sleep_req_n),
    .stop_req_n(stop_req_n), .hold_act(hold_act),
    .watch({stop_req_n, halt_req, snoop_act, bus_intr, ack_resp, evt_in}),
    .slp_err(slp_err), .hold_err(hold_err), .bus_err(bus_err)
  );

  assign state_o  = st;
  assign ack_req  = (st == PS_ACKW);
  assign clk_en   = (st != PS_SLP);
  assign pll_keep = (st == PS_SLP);
  assign pbe      = (st == PS_STPG) && (|pend);
  assign svc_o    = (st == PS_NORM) ? pend : '0;
endmodule

// File: rtl/lp_state_seq_chk.sv
module lp_state_seq_chk #(
  parameter int ENTRY_DLY = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_o,
  input logic       clk_en,
  input logic       pll_keep,
  input logic       pbe,
  input logic [4:0] svc_o,
  input logic       bus_err
);
  localparam int KW = $clog2(ENTRY_DLY + 2);
  logic [KW-1:0] ent_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ent_cycles <= '0;
    else if (state_o == 3'd3) ent_cycles <= ent_cycles + 1'b1;
    else                      ent_cycles <= '0;
  end

  assert_entry_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && ent_cycles != '0) |-> ent_cycles == KW'(ENTRY_DLY));

  assert_sleep_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |-> ($past(state_o) == 3'd4 || $past(state_o) == 3'd6));

  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |-> (!clk_en && pll_keep));

  assert_snoop_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd5 && state_o != 3'd5) |-> (state_o == 3'd4 || state_o == 3'd1));

  assert_svc_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_o != '0) |=> (svc_o == '0));

  assert_pbe_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pbe |-> (state_o == 3'd4));

  assert_bus_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> bus_err);
endmodule

bind lp_state_seq lp_state_seq_chk #(.ENTRY_DLY(ENTRY_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_o(state_o), .clk_en(clk_en),
  .pll_keep(pll_keep), .pbe(pbe), .svc_o(svc_o), .bus_err(bus_err)
);

// File: tb/tb_lp_state_seq.sv
module tb_lp_state_seq;
  localparam int CLK_PERIOD = 10;
  localparam int D = 5;
  localparam int H = 4;

  logic       clk, rst_n, stop_req_n, sleep_req_n, core_rst_n;
  logic       halt_req, snoop_act, bus_intr, ack_resp;
  logic [3:0] evt_in;
  logic [2:0] state_o;
  logic       ack_req, clk_en, pll_keep, pbe, slp_err, hold_err, bus_err;
  logic [4:0] svc_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  lp_state_seq #(.ENTRY_DLY(D), .MIN_HOLD(H)) dut (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .sleep_req_n(sleep_req_n),
    .core_rst_n(core_rst_n), .halt_req(halt_req), .snoop_act(snoop_act),
    .bus_intr(bus_intr), .ack_resp(ack_resp), .evt_in(evt_in),
    .state_o(state_o), .ack_req(ack_req), .clk_en(clk_en), .pll_keep(pll_keep),
    .pbe(pbe), .svc_o(svc_o), .slp_err(slp_err), .hold_err(hold_err),
    .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    stop_req_n = 1; sleep_req_n = 1; core_rst_n = 1; halt_req = 0;
    snoop_act = 0; bus_intr = 0; ack_resp = 0; evt_in = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic go_sg(input bit check);
    stop_req_n = 0;
    step();
    if (check) begin
      chk("R1 ackwait state", state_o, 2);
      chk("R1 ack_req", ack_req, 1);
    end
    ack_resp = 1;
    step();
    ack_resp = 0;
    if (check) chk("R1 entry state", state_o, 3);
    for (int i = 1; i < D; i++) begin
      step();
      if (check) chk("R1 still counting", state_o, 3);
    end
    step();
    chk("R1 stop-grant reached", state_o, 4);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    chk("reset state", state_o, 0);
    chk("reset clk_en R5", clk_en, 1);
    chk("reset ack_req", ack_req, 0);
    chk("reset errors", {slp_err, hold_err, bus_err}, 0);

    // R11 autohalt and priority
    halt_req = 1; step();
    chk("R11 enter halt", state_o, 1);
    halt_req = 0; step();
    chk("R11 leave halt", state_o, 0);
    halt_req = 1; stop_req_n = 0; step();
    chk("R11 stop priority", state_o, 2);
    halt_req = 0;
    do_reset();

    // R1 / R8 / R9 / R2: sweep every side-band mask
    for (int m = 0; m < 16; m++) begin
      go_sg(m == 0);
      chk("R9 pbe idle", pbe, 0);
      evt_in = 4'(m); step();
      evt_in = '0; step();
      evt_in = 4'(m); step();
      evt_in = '0; step();
      chk("R9 pbe pending", pbe, (m != 0) ? 1 : 0);
      stop_req_n = 1; step();
      chk("R2 back to normal", state_o, 0);
      chk("R8 svc once", svc_o, m);
      chk("R9 pbe off in normal", pbe, 0);
      step();
      chk("R8 svc cleared", svc_o, 0);
    end

    // R7 snoop from stop-grant
    go_sg(0);
    snoop_act = 1; step();
    chk("R7 snoop from sg", state_o, 5);
    step();
    chk("R7 snoop holds", state_o, 5);
    snoop_act = 0; step();
    chk("R7 return sg", state_o, 4);
    // R3 core reset in stop-grant
    core_rst_n = 0; step();
    chk("R3 stays sg", state_o, 4);
    core_rst_n = 1; stop_req_n = 1; step();
    chk("R2 exit", state_o, 0);

    // R7 / R8 from autohalt with bus interrupt
    halt_req = 1; step();
    bus_intr = 1; step();
    bus_intr = 0;
    chk("R7 intr from halt", state_o, 5);
    step();
    chk("R7 return halt", state_o, 1);
    halt_req = 0; step();
    chk("R11 exit halt", state_o, 0);
    chk("R8 bus intr svc", svc_o, 16);
    step();

    // R3 core reset in autohalt clears latch
    halt_req = 1; step();
    bus_intr = 1; step();
    bus_intr = 0; step();
    chk("R7 back to halt", state_o, 1);
    core_rst_n = 0; step();
    chk("R3 forced normal", state_o, 0);
    chk("R3 latch cleared", svc_o, 0);
    core_rst_n = 1; halt_req = 0; step();

    // R4 illegal sleep request
    sleep_req_n = 0; step();
    chk("R4 no transition", state_o, 0);
    chk("R4 slp_err", slp_err, 1);
    sleep_req_n = 1; step();
    chk("R4 sticky", slp_err, 1);
    do_reset();

    // R6 early-release sweep after sleep
    for (int k = 1; k <= H + 2; k++) begin
      do_reset();
      go_sg(0);
      sleep_req_n = 0; step();
      chk("R4 enter sleep", state_o, 6);
      chk("R5 clk gated", clk_en, 0);
      chk("R5 pll kept", pll_keep, 1);
      sleep_req_n = 1; step();
      chk("R6 back to sg", state_o, 4);
      chk("R5 clk on", clk_en, 1);
      for (int j = 1; j < k; j++) step();
      stop_req_n = 1; step();
      chk("R6 exit normal", state_o, 0);
      chk("R6 hold_err", hold_err, (k < H) ? 1 : 0);
      chk("R10 no bus err", bus_err, 0);
    end

    // R5 / R10 snoop in sleep
    do_reset();
    go_sg(0);
    sleep_req_n = 0; step();
    step();
    chk("R10 clean so far", bus_err, 0);
    snoop_act = 1; step();
    chk("R5 snoop ignored", state_o, 6);
    chk("R10 bus_err set", bus_err, 1);
    snoop_act = 0; step();
    sleep_req_n = 1; step();
    chk("R10 sticky", bus_err, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule